// File: doc/BRIEF.md
# Hierarchical State Machine with History Return

This block is a two-level synchronous state machine. It has one outer state, called the idle state here, and one grouping state that holds a ring of basic sub-states. A trap pulse sends the machine from any sub-state out to the idle state. A resume pulse brings it back into the group. On the first entry after reset, the group starts at a fixed default sub-state. On every later entry, it starts at the sub-state it held when it last left. While inside the group, a step pulse moves the machine one place around the ring.

Every input is a one-cycle pulse. Each pulse is latched into an event register for exactly one step and then expires. During that step the next state and the next history value are computed as temporary values. Both are committed together on the following clock edge, so the result never depends on evaluation order. The outputs are a one-hot sub-state vector and two flags that say whether the machine is in the group or idle.

Top module: `hfsm_hist_top`

## Requirements
- R1: After reset the machine is idle: `in_z_o`=1, `in_s_o`=0, `sub_oh_o`=0, and the history is marked unused.
- R2: While `in_s_o`=1, exactly one bit of `sub_oh_o` is set. While idle, `sub_oh_o` is all zero. Bit i stands for sub-state i, with i=0 being sub-state A.
- R3: A step pulse inside the group moves the active bit from bit i to bit i+1, and from the top bit back to bit 0 (A→B→C→D→E→A).
- R4: A trap pulse in any sub-state makes the machine idle.
- R5: The first resume pulse after reset enters the group at sub-state A (`sub_oh_o`=00001).
- R6: Every later resume pulse enters the group at the sub-state that was active when the group was last left.
- R7: A pulse sampled at a clock edge changes the outputs at the second edge after it. A pulse changes the state once only and then expires.
- R8: When a trap and a resume arrive in the same cycle, only the one valid in the current state is acted on. Inside the group, a trap takes priority over a step, and the history records the sub-state held before that step.
- R9: Step and trap pulses have no effect while idle. A resume pulse has no effect inside the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_i | input | 1 | Trap pulse: leave the group for the idle state |
| ret_i | input | 1 | Resume pulse: enter the group from the idle state |
| adv_i | input | 1 | Step pulse: next sub-state around the ring |
| sub_oh_o | output | NUM_SUB | One-hot active sub-state (zero while idle) |
| in_s_o | output | 1 | Machine is inside the group |
| in_z_o | output | 1 | Machine is in the idle state |

## Verification
The hardest case to reach is resuming at a history value that differs from the default after the group has been left more than once. A wrong design that always resumes at A, or that records the history one step late, looks correct on the first entry. The stimulus therefore walks the ring to C, traps, and resumes. It then walks to E, traps, and resumes again. Finally it traps together with a simultaneous step, which shows that the committed history is the pre-step sub-state.

// File: rtl/hfsm_pkg.sv
package hfsm_pkg;
  typedef enum logic {TOP_Z = 1'b0, TOP_S = 1'b1} top_e;
  typedef struct packed {
    logic exc;
    logic ret;
    logic adv;
  } evt_t;
endpackage

// File: rtl/hfsm_evt_reg.sv
module hfsm_evt_reg
  import hfsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t evt_i,
  output evt_t evt_o
);
  // always enabled: an event lives for one step only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= evt_i;
  end
endmodule

// File: rtl/hfsm_history.sv
module hfsm_history #(
  parameter int NUM_SUB = 5,
  parameter int DEF_SUB = 0,
  localparam int SW = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          leave_i,
  input  logic [SW-1:0] cur_sub_i,
  output logic [SW-1:0] entry_sub_o,
  output logic          seen_o
);
  logic [SW-1:0] hist_q, hist_d;
  logic          seen_q, seen_d;

  always_comb begin
    hist_d = hist_q;
    seen_d = seen_q;
    if (leave_i) begin
      hist_d = cur_sub_i;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= SW'(DEF_SUB);
      seen_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      seen_q <= seen_d;
    end
  end

  assign entry_sub_o = seen_q ? hist_q : SW'(DEF_SUB);
  assign seen_o      = seen_q;
endmodule

// File: rtl/hfsm_oh_dec.sv
module hfsm_oh_dec #(
  parameter int NUM_SUB = 5,
  localparam int SW = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic               en_i,
  input  logic [SW-1:0]      idx_i,
  output logic [NUM_SUB-1:0] oh_o
);
  for (genvar g = 0; g < NUM_SUB; g++) begin : g_bit
    assign oh_o[g] = en_i && (idx_i == SW'(g));
  end
endmodule

// File: rtl/hfsm_hist_top.sv
module hfsm_hist_top
  import hfsm_pkg::*;
#(
  parameter int NUM_SUB = 5,
  parameter int DEF_SUB = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_i,
  input  logic               ret_i,
  input  logic               adv_i,
  output logic [NUM_SUB-1:0] sub_oh_o,
  output logic               in_s_o,
  output logic               in_z_o
);
  localparam int SW = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;
  localparam logic [SW-1:0] LAST = SW'(NUM_SUB - 1);

  evt_t          evt_in, evt_q;
  top_e          top_q, top_d;
  logic [SW-1:0] sub_q, sub_d, entry_sub, ring_nxt;
  logic          leave, seen;

  assign evt_in = '{exc: exc_i, ret: ret_i, adv: adv_i};

  hfsm_evt_reg u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_in),
    .evt_o (evt_q)
  );

  assign ring_nxt = (sub_q == LAST) ? '0 : sub_q + SW'(1);

  // phase 2: compute all next values; phase 3 is the shared clock edge
  always_comb begin
    top_d = top_q;
    sub_d = sub_q;
    leave = 1'b0;
    unique case (top_q)
      TOP_Z: if (evt_q.ret) begin
        top_d = TOP_S;
        sub_d = entry_sub;
      end
      TOP_S: if (evt_q.exc) begin
        top_d = TOP_Z;
        leave = 1'b1;
      end else if (evt_q.adv) begin
        sub_d = ring_nxt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= TOP_Z;
      sub_q <= SW'(DEF_SUB);
    end else begin
      top_q <= top_d;
      sub_q <= sub_d;
    end
  end

  hfsm_history #(.NUM_SUB(NUM_SUB), .DEF_SUB(DEF_SUB)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .leave_i    (leave),
    .cur_sub_i  (sub_q),
    .entry_sub_o(entry_sub),
    .seen_o     (seen)
  );

  assign in_s_o = (top_q == TOP_S);
  assign in_z_o = (top_q == TOP_Z);

  hfsm_oh_dec #(.NUM_SUB(NUM_SUB)) u_dec (
    .en_i (in_s_o),
    .idx_i(sub_q),
    .oh_o (sub_oh_o)
  );
endmodule

// File: rtl/hfsm_hist_chk.sv
module hfsm_hist_chk #(
  parameter int NUM_SUB = 5,
  parameter int DEF_SUB = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_i,
  input logic               ret_i,
  input logic               adv_i,
  input logic [NUM_SUB-1:0] sub_oh_o,
  input logic               in_s_o,
  input logic               seen_i
);
  function automatic logic [NUM_SUB-1:0] rot(input logic [NUM_SUB-1:0] x);
    return {x[NUM_SUB-2:0], x[NUM_SUB-1]};
  endfunction

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s_o |-> $countones(sub_oh_o) == 1);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_s_o |-> sub_oh_o == '0);
  p_ring_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s_o && $past(adv_i) && !$past(exc_i) |=> sub_oh_o == rot($past(sub_oh_o)));
  p_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s_o && $past(exc_i) |=> !in_s_o);
  p_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_s_o && $past(ret_i) && !seen_i |=> sub_oh_o == (NUM_SUB'(1) << DEF_SUB));
  p_stay_s_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s_o && !$past(exc_i) |=> in_s_o);
  p_hold_z_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_s_o && !$past(ret_i) |=> !in_s_o);
endmodule

bind hfsm_hist_top hfsm_hist_chk #(.NUM_SUB(NUM_SUB), .DEF_SUB(DEF_SUB)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exc_i   (exc_i),
  .ret_i   (ret_i),
  .adv_i   (adv_i),
  .sub_oh_o(sub_oh_o),
  .in_s_o  (in_s_o),
  .seen_i  (seen)
);

// File: tb/sim_hfsm_hist_top.sv
`timescale 1ns/1ps
module sim_hfsm_hist_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       exc_i = 1'b0, ret_i = 1'b0, adv_i = 1'b0;
  logic [4:0] sub_oh_o;
  logic       in_s_o, in_z_o;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hfsm_hist_top #(.NUM_SUB(5), .DEF_SUB(0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .exc_i(exc_i), .ret_i(ret_i), .adv_i(adv_i),
    .sub_oh_o(sub_oh_o), .in_s_o(in_s_o), .in_z_o(in_z_o)
  );

  task automatic chk(input string req, input logic [4:0] exp_oh, input logic exp_s);
    total++;
    if (sub_oh_o !== exp_oh || in_s_o !== exp_s || in_z_o !== !exp_s) begin
      bad++;
      $display("FAIL %s: got oh=%b s=%b z=%b exp oh=%b s=%b z=%b",
               req, sub_oh_o, in_s_o, in_z_o, exp_oh, exp_s, !exp_s);
    end
  endtask

  // drive at a negedge, clear one cycle later, outputs settle one more cycle later
  task automatic fire(input logic e, input logic r, input logic a);
    @(negedge clk_i);
    exc_i = e; ret_i = r; adv_i = a;
    @(negedge clk_i);
    exc_i = 0; ret_i = 0; adv_i = 0;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exc_i = 0; ret_i = 0; adv_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 reset idle", 5'b00000, 1'b0);
  endtask

  task automatic t_first_entry_r5();
    fire(0, 1, 0);
    chk("R5 first entry at A", 5'b00001, 1'b1);
  endtask

  task automatic t_latency_r7();
    @(negedge clk_i);
    adv_i = 1;
    @(negedge clk_i);
    adv_i = 0;
    chk("R7 no change after one edge", 5'b00001, 1'b1);
    @(negedge clk_i);
    chk("R7 change at second edge", 5'b00010, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R7 pulse expired, single step", 5'b00010, 1'b1);
  endtask

  task automatic t_ring_r3();
    // currently at B; walk C,D,E,A,B
    logic [4:0] exp = 5'b00010;
    for (int i = 0; i < 5; i++) begin
      fire(0, 0, 1);
      exp = {exp[3:0], exp[4]};
      chk("R3 ring step", exp, 1'b1);
    end
  endtask

  task automatic t_exit_history_r4_r6();
    fire(0, 0, 1);                 // B -> C
    chk("R3 step to C", 5'b00100, 1'b1);
    fire(1, 0, 0);
    chk("R4 trap from C", 5'b00000, 1'b0);
    fire(0, 0, 1);
    chk("R9 step ignored idle", 5'b00000, 1'b0);
    fire(1, 0, 0);
    chk("R9 trap ignored idle", 5'b00000, 1'b0);
    fire(0, 1, 0);
    chk("R6 resume at C", 5'b00100, 1'b1);
    fire(0, 0, 1);
    fire(0, 0, 1);
    chk("R3 step to E", 5'b10000, 1'b1);
    fire(1, 0, 0);
    chk("R4 trap from E", 5'b00000, 1'b0);
    fire(0, 1, 0);
    chk("R6 resume at E", 5'b10000, 1'b1);
    fire(0, 1, 0);
    chk("R9 resume ignored in group", 5'b10000, 1'b1);
  endtask

  task automatic t_both_r8();
    fire(1, 1, 0);
    chk("R8 trap+resume in group exits", 5'b00000, 1'b0);
    fire(1, 1, 0);
    chk("R8 trap+resume idle enters at E", 5'b10000, 1'b1);
    fire(1, 0, 1);
    chk("R8 trap beats step", 5'b00000, 1'b0);
    fire(0, 1, 0);
    chk("R8 history is pre-step E", 5'b10000, 1'b1);
  endtask

  task automatic t_each_exit_r4();
    for (int i = 0; i < 5; i++) begin
      logic [4:0] exp = 5'b00001 << i;
      do_reset();
      fire(0, 1, 0);
      for (int j = 0; j < i; j++) fire(0, 0, 1);
      chk("R2 one-hot before trap", exp, 1'b1);
      fire(1, 0, 0);
      chk("R4 trap from sub-state", 5'b00000, 1'b0);
      fire(0, 1, 0);
      chk("R6 resume matches", exp, 1'b1);
    end
  endtask

  task automatic t_reset_clears_r1();
    do_reset();
    chk("R1 reset after use", 5'b00000, 1'b0);
    fire(0, 1, 0);
    chk("R5 entry at A after reset clears history", 5'b00001, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset_r1();
    t_first_entry_r5();
    t_latency_r7();
    t_ring_r3();
    t_exit_history_r4_r6();
    t_both_r8();
    t_each_exit_r4();
    t_reset_clears_r1();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end
endmodule